// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block sits between a clocked host and an external asynchronous static RAM of 128K bytes. The host issues one single-byte read or write at a time. The block turns each request into a pin-level access with two chip selects (one active low, one active high), an active-low write strobe, an active-low output enable, a 17-bit address and a byte-wide data bus. The data bus is split into an input, an output and an output-enable for the pad. Every timing interval is a parameter counted in clock cycles, so the block can be retuned for a different clock period.

Each write ends by raising the write strobe while the chip stays selected. Address and data are held for one more cycle after that edge. Before any data is driven, output enable is kept high for a turnaround interval, so the RAM and the block never drive the bus at the same time. For a read, the block holds the address and output enable low for a set number of cycles. It then samples the bus into a host-side register and pulses a completion flag.

Top module: `sram_port_ctl`

## Requirements
- R1: While reset is low, and in the first cycle after it, the pins are inactive: chip select low-active pin at 1, chip select high-active pin at 0, write strobe at 1, output enable at 1, bus driver off. At the same time ready is 1, done is 0 and the read data register is 0. Reset is asynchronous, so it also aborts an access in progress at once.
- R2: The two chip-select pins are always complementary. The chip is selected in every cycle from the one after a request is accepted up to and including the done cycle. It is deselected in all other cycles.
- R3: A read keeps output enable low for exactly RD_CYC cycles after acceptance. During those cycles the write strobe is high and the bus is not driven. At the end of the last such cycle the bus is sampled into the read data output. Output enable is high again in the done cycle.
- R4: A write first spends TURN_CYC cycles selected, with the write strobe high, output enable high and the bus undriven. It then holds the write strobe low for exactly WE_CYC cycles while driving the host's write byte.
- R5: A write ends by the rising edge of the write strobe while the chip is still selected. The write byte stays driven through the following done cycle.
- R6: Output enable is high throughout every write. Output enable low and the bus driver never coincide.
- R7: A request is taken only when ready is 1. ready is 1 exactly in the idle state. Requests presented while busy are ignored. done is a one-cycle pulse at the end of every access and is followed by ready.
- R8: The address pins equal the accepted host address from acceptance until the next accepted request.
- R9: The write strobe is never low while ready is 1.
- R10: The read data output keeps its value across write accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request valid |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Host byte address |
| wdata_i | input | 8 | Host write byte |
| ready_o | output | 1 | Idle, request will be taken |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Last byte read |
| sram_addr_o | output | 17 | RAM address pins |
| sram_dq_i | input | 8 | RAM data bus, pad input |
| sram_dq_o | output | 8 | RAM data bus, pad output |
| sram_dq_oe_o | output | 1 | Pad output enable for the data bus |
| sram_ce1_n_o | output | 1 | Chip select, active low |
| sram_ce2_o | output | 1 | Chip select, active high |
| sram_we_n_o | output | 1 | Write strobe, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |

## Verification
The assertions assume that req_i, wr_i, addr_i and wdata_i are stable around the clock edge. They also assume that the pad input reflects only what the RAM drives while output enable is low. The stimulus changes host inputs and the pad input only at falling clock edges. During reads it holds the bus value constant for the whole output-enable window. While busy, it deliberately presents a conflicting request, so that the ignore rule is exercised without breaking those assumptions.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_WAIT,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_DONE
  } ctl_state_e;
endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq import sram_ctl_pkg::*; #(
  parameter int RD_CYC   = 2,
  parameter int TURN_CYC = 1,
  parameter int WE_CYC   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       wr_i,
  output ctl_state_e state_o,
  output ctl_state_e state_d_o,
  output logic       accept_o,
  output logic       sample_o
);
  localparam int MAX_A   = (RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC;
  localparam int MAX_CYC = (MAX_A > WE_CYC) ? MAX_A : WE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctl_state_e       state_q, state_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             zero;

  sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (load_val),
    .zero_o (zero)
  );

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        load = 1'b1;
        if (wr_i) begin
          state_d  = ST_WR_SETUP;
          load_val = CNT_W'(TURN_CYC - 1);
        end else begin
          state_d  = ST_READ_WAIT;
          load_val = CNT_W'(RD_CYC - 1);
        end
      end
      ST_READ_WAIT: if (zero) state_d = ST_DONE;
      ST_WR_SETUP: if (zero) begin
        state_d  = ST_WR_PULSE;
        load     = 1'b1;
        load_val = CNT_W'(WE_CYC - 1);
      end
      ST_WR_PULSE: if (zero) state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign state_d_o = state_d;
  assign accept_o  = (state_q == ST_IDLE) && req_i;
  assign sample_o  = (state_q == ST_READ_WAIT) && zero;

  // R7
  done_then_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));
  // R7
  busy_no_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> ((state_q != ST_READ_WAIT && state_q != ST_WR_SETUP) || $stable(state_q) || $past(state_q) == ST_IDLE));
endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv import sram_ctl_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  ctl_state_e state_d_i,
  input  logic       wr_d_i,
  output logic       ce1_n_o,
  output logic       ce2_o,
  output logic       we_n_o,
  output logic       oe_n_o,
  output logic       dq_oe_o
);
  logic sel_d, oe_d, we_d, drv_d;

  always_comb begin
    sel_d = (state_d_i != ST_IDLE);
    oe_d  = (state_d_i == ST_READ_WAIT);
    we_d  = (state_d_i == ST_WR_PULSE);
    drv_d = (state_d_i == ST_WR_PULSE) || ((state_d_i == ST_DONE) && wr_d_i);
  end

  // pins are registered from next state so they switch glitch-free with it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce1_n_o <= 1'b1;
      ce2_o   <= 1'b0;
      we_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      ce1_n_o <= !sel_d;
      ce2_o   <= sel_d;
      we_n_o  <= !we_d;
      oe_n_o  <= !oe_d;
      dq_oe_o <= drv_d;
    end
  end

  // R6
  no_bus_fight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_n_o && dq_oe_o));
  // R2
  sel_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce1_n_o == !ce2_o);
  // R4
  we_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> (dq_oe_o && !ce1_n_o));
endmodule

// File: rtl/sram_port_ctl.sv
module sram_port_ctl import sram_ctl_pkg::*; #(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int RD_CYC   = 2,
  parameter int TURN_CYC = 1,
  parameter int WE_CYC   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  output logic              sram_ce1_n_o,
  output logic              sram_ce2_o,
  output logic              sram_we_n_o,
  output logic              sram_oe_n_o
);
  localparam int WCNT_W = $clog2(WE_CYC + 2);

  ctl_state_e        state_q, state_d;
  logic              accept, sample;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  sram_ctl_seq #(
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC),
    .WE_CYC   (WE_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .wr_i      (wr_i),
    .state_o   (state_q),
    .state_d_o (state_d),
    .accept_o  (accept),
    .sample_o  (sample)
  );

  assign wr_d = accept ? wr_i : wr_q;

  sram_pin_drv u_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_d_i (state_d),
    .wr_d_i    (wr_d),
    .ce1_n_o   (sram_ce1_n_o),
    .ce2_o     (sram_ce2_o),
    .we_n_o    (sram_we_n_o),
    .oe_n_o    (sram_oe_n_o),
    .dq_oe_o   (sram_dq_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= wr_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (sample) rdata_q <= sram_dq_i;
  end

  assign ready_o     = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign rdata_o     = rdata_q;
  assign sram_addr_o = addr_q;
  assign sram_dq_o   = wdata_q;

  // checker state: length of the current write strobe
  logic [WCNT_W-1:0] we_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           we_cnt_q <= '0;
    else if (!sram_we_n_o) we_cnt_q <= we_cnt_q + 1'b1;
    else                   we_cnt_q <= '0;
  end

  // R4
  we_pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_n_o) |-> (we_cnt_q == WCNT_W'(WE_CYC)));
  // R5
  we_end_selected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_n_o) |-> (!sram_ce1_n_o && sram_ce2_o && sram_dq_oe_o));
  // R8
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(sram_addr_o));
  // R9
  idle_no_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> sram_we_n_o);
  // R3
  sample_under_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample |-> !sram_oe_n_o);
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && ready_o));
  // R10
  rdata_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q && !ready_o) |=> $stable(rdata_o));
endmodule

// File: tb/sim_sram_port_ctl.sv
module sim_sram_port_ctl;
  localparam int RD = 2, TURN = 1, WE = 2;
  localparam int NV = 8;
  // {wr, addr, wdata, bus value presented on reads}
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 17'h00000, 8'hA5, 8'h00},
    {1'b0, 17'h1FFFF, 8'h00, 8'h3C},
    {1'b1, 17'h1FFFF, 8'hFF, 8'h00},
    {1'b0, 17'h00000, 8'h00, 8'h00},
    {1'b0, 17'h0AAAA, 8'h11, 8'h5A},
    {1'b1, 17'h15555, 8'h00, 8'h77},
    {1'b1, 17'h00001, 8'h81, 8'h00},
    {1'b0, 17'h10000, 8'h00, 8'hC3}
  };

  logic clk = 0;
  always #4 clk = ~clk;

  logic        rst_ni, req, wr;
  logic [16:0] addr;
  logic [7:0]  wdata, dq_in;
  logic        ready, done, dq_oe, ce1_n, ce2, we_n, oe_n;
  logic [7:0]  rdata, dq_out;
  logic [16:0] sram_addr;
  int checks = 0, fails = 0;

  sram_port_ctl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .done_o(done), .rdata_o(rdata),
    .sram_addr_o(sram_addr), .sram_dq_i(dq_in), .sram_dq_o(dq_out),
    .sram_dq_oe_o(dq_oe), .sram_ce1_n_o(ce1_n), .sram_ce2_o(ce2),
    .sram_we_n_o(we_n), .sram_oe_n_o(oe_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_pins(input string tag);
    chk({tag, " ce1_n"}, 32'(ce1_n), 1);
    chk({tag, " ce2"}, 32'(ce2), 0);
    chk({tag, " we_n"}, 32'(we_n), 1);
    chk({tag, " oe_n"}, 32'(oe_n), 1);
    chk({tag, " dq_oe"}, 32'(dq_oe), 0);
    chk({tag, " ready"}, 32'(ready), 1);
    chk({tag, " done"}, 32'(done), 0);
  endtask

  task automatic access(input logic w, input logic [16:0] a, input logic [7:0] d, input logic [7:0] rv);
    logic [7:0] prev;
    prev = rdata;
    @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d; dq_in = rv;
    @(negedge clk);
    // conflicting request while busy must be ignored (R7)
    wr = ~w; addr = ~a; wdata = ~d;
    if (!w) begin
      for (int k = 1; k <= RD; k++) begin
        if (k > 1) @(negedge clk);
        chk("R3 oe_n low", 32'(oe_n), 0);
        chk("R3 we_n high", 32'(we_n), 1);
        chk("R2 ce1_n", 32'(ce1_n), 0);
        chk("R2 ce2", 32'(ce2), 1);
        chk("R8 addr", 32'(sram_addr), 32'(a));
        chk("R7 busy ready", 32'(ready), 0);
        chk("R6 no drive on read", 32'(dq_oe), 0);
      end
      @(negedge clk);
      chk("R7 done", 32'(done), 1);
      chk("R3 rdata", 32'(rdata), 32'(rv));
      chk("R3 oe_n back high", 32'(oe_n), 1);
      chk("R2 selected in done", 32'(ce1_n), 0);
    end else begin
      for (int k = 1; k <= TURN; k++) begin
        if (k > 1) @(negedge clk);
        chk("R4 turn we_n", 32'(we_n), 1);
        chk("R4 turn oe_n", 32'(oe_n), 1);
        chk("R4 turn dq_oe", 32'(dq_oe), 0);
        chk("R4 turn ce1_n", 32'(ce1_n), 0);
        chk("R7 busy ready", 32'(ready), 0);
      end
      for (int k = 1; k <= WE; k++) begin
        @(negedge clk);
        chk("R4 we_n low", 32'(we_n), 0);
        chk("R4 dq_oe", 32'(dq_oe), 1);
        chk("R4 dq_o", 32'(dq_out), 32'(d));
        chk("R8 addr", 32'(sram_addr), 32'(a));
        chk("R6 oe_n high in write", 32'(oe_n), 1);
        chk("R9 not ready", 32'(ready), 0);
      end
      @(negedge clk);
      chk("R5 we_n risen", 32'(we_n), 1);
      chk("R5 ce1_n held", 32'(ce1_n), 0);
      chk("R5 ce2 held", 32'(ce2), 1);
      chk("R5 dq_oe held", 32'(dq_oe), 1);
      chk("R5 dq_o held", 32'(dq_out), 32'(d));
      chk("R7 done", 32'(done), 1);
      chk("R10 rdata kept", 32'(rdata), 32'(prev));
    end
    req = 0;
    @(negedge clk);
    idle_pins("R7 after done");
    chk("R7 ignored req left addr", 32'(sram_addr), 32'(a));
  endtask

  initial begin
    #1600000;
    checks++; fails++;
    $display("FAIL R7 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_ni = 0; req = 0; wr = 0; addr = '0; wdata = '0; dq_in = '0;
    #20;
    idle_pins("R1 in reset");
    chk("R1 rdata reset", 32'(rdata), 0);
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    idle_pins("R1 after reset");

    for (int i = 0; i < NV; i++)
      access(VEC[i][33], VEC[i][32:16], VEC[i][15:8], VEC[i][7:0]);

    // no request: stays idle (R7)
    repeat (3) @(negedge clk);
    idle_pins("R7 no request");

    // reset in the middle of a write pulse aborts it (R1)
    @(negedge clk);
    req = 1; wr = 1; addr = 17'h01234; wdata = 8'h9C;
    @(negedge clk); req = 0;
    repeat (TURN) @(negedge clk);
    chk("R4 pulse reached", 32'(we_n), 0);
    rst_ni = 0;
    #1;
    idle_pins("R1 abort");
    chk("R1 rdata cleared", 32'(rdata), 0);
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    idle_pins("R1 after abort");

    // recovery and back-to-back accesses
    access(1'b0, 17'h0F0F0, 8'h00, 8'h96);
    access(1'b1, 17'h0F0F0, 8'h69, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule